// File: doc/BRIEF.md
# Serial Test Port Host Sequencer

This block is the host end of a serial test access port link. It takes one command at a time and turns it into the test clock, mode-select and serial data waveforms that walk a chain of test ports through its state machine. Each command is one of three kinds: a forced reset, an instruction-register scan or a data-register scan. A scan carries a bit count and a payload. The block captures the bits the chain returns, presents them with a one-cycle done pulse, and then goes back to idle with the chain parked in Run-Test/Idle.

Commands use a valid/ready handshake. A command is taken on a clock where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the done pulse, so the caller holds the next command on the port until the engine is free. Back-pressure applies only on the command side. `rsp_valid` is a plain pulse that cannot be stalled, and `rsp_data` keeps its value until the next command is accepted. Each command carries its own scan length, and its own value for the half-period of the test clock. The caller pads a scan for the other devices in the chain by adding bits to the length.

Top module: `tap_host_seq`

## Requirements
- R1: While reset is applied and after it is released, `cmd_ready` is 1 and `tck`, `tms`, `tdi` and `rsp_valid` are 0.
- R2: A command is accepted on a clock with `cmd_valid` and `cmd_ready` both high. From the next clock, `cmd_ready` is 0 until the cycle of the done pulse. `rsp_valid` is high for exactly one clock per command, and `cmd_ready` is 1 in that cycle.
- R3: Op code 0 (reset) drives `tms` to 1 for five test-clock periods and then to 0 for one period. It passes through Test-Logic-Reset from any starting state and ends in Run-Test/Idle. No data is shifted.
- R4: Op codes 2 and 3 (data scan) give the `tms` sequence 1,0,0. This is followed by N shift periods, with `tms` at 0 except on the last one, where it is 1. The sequence ends with 1,0. The chain ends in Run-Test/Idle.
- R5: Op code 1 (instruction scan) gives the `tms` sequence 1,1,0,0. This is followed by the same N shift periods and 1,0 ending as in R4.
- R6: During the i-th shift period (counting from 0), `tdi` carries bit i of `cmd_data`, so the payload is sent least-significant bit first.
- R7: `tdo` is sampled on the clock where `tck` rises in each shift period. The i-th sample goes into bit i of `rsp_data`. Bits at positions N and above are 0. `rsp_data` is valid from the done pulse until the next acceptance.
- R8: The scan length N comes from `cmd_len` for each command and is anything from 1 to MAX_BITS. A length of 0 is used as 1, and a length above MAX_BITS is used as MAX_BITS.
- R9: `tms` and `tdi` change only in the clock where `tck` falls, or while `tck` is low. They never change in the clock where `tck` rises.
- R10: Each high phase and each low phase of `tck` lasts `clk_div`+1 clocks. The value is latched when the command is accepted.
- R11: Between commands, `tck`, `tms` and `tdi` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine free to take a command |
| cmd_op | input | 2 | 0 reset, 1 instruction scan, 2 or 3 data scan |
| cmd_len | input | $clog2(MAX_BITS+1) | Number of bits to shift |
| cmd_data | input | MAX_BITS | Payload, sent LSB first |
| clk_div | input | DIV_W | Test-clock half-period minus one, in clocks |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | MAX_BITS | Captured bits, LSB first |
| tck | output | 1 | Test clock |
| tms | output | 1 | Mode select |
| tdi | output | 1 | Serial data toward the chain |
| tdo | input | 1 | Serial data returned by the chain |

## Verification
The bench builds the block with MAX_BITS=64 and DIV_W=4. With MAX_BITS at 64, a full-width 64-bit scan and a 1-bit scan both run, and so does a scan longer than the target's 8-bit register, which checks the padding behaviour. The bench's own port model has a 4-bit instruction register, an 8-bit data register and a 1-bit bypass. With DIV_W at 4, divider values from 0 to 3 keep the run short while still covering the tightest timing, where each phase lasts one clock and `tdo` changes right next to the capture clock.

// File: rtl/tap_host_pkg.sv
package tap_host_pkg;
  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_IR     = 2'd1,
    OP_DR     = 2'd2,
    OP_DR_ALT = 2'd3
  } tap_op_e;

  typedef enum logic [1:0] {
    NV_IDLE,
    NV_PRE,
    NV_SHIFT,
    NV_POST
  } nav_state_e;

  localparam int unsigned PRE_W = 6;
endpackage

// File: rtl/tap_tck_gen.sv
module tap_tck_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             level,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = run && (cnt == half_div);
  assign rise = wrap && !level;
  assign fall = wrap && level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      level <= ~level;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tap_nav_fsm.sv
module tap_nav_fsm
  import tap_host_pkg::*;
#(
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  tap_op_e          op,
  input  logic [LEN_W-1:0] len,
  input  logic             rise,
  input  logic             fall,
  output logic             busy,
  output logic             tms,
  output logic             in_shift,
  output logic             shift_rise,
  output logic             shift_fall,
  output logic [LEN_W-1:0] idx,
  output logic             done
);
  localparam logic [LEN_W-1:0] ONE = 1;

  nav_state_e       st;
  logic [PRE_W-1:0] pre_pat;
  logic [2:0]       pre_left;
  logic [LEN_W-1:0] len_q;
  logic             is_reset;
  logic             post_second;
  logic             last_bit;

  assign last_bit   = (idx + ONE) == len_q;
  assign busy       = (st != NV_IDLE);
  assign in_shift   = (st == NV_SHIFT);
  assign shift_rise = in_shift && rise;
  assign shift_fall = in_shift && fall;

  always_comb begin
    case (st)
      NV_PRE:   tms = pre_pat[0];
      NV_SHIFT: tms = last_bit;
      NV_POST:  tms = !post_second;
      default:  tms = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= NV_IDLE;
      pre_pat     <= '0;
      pre_left    <= '0;
      len_q       <= ONE;
      is_reset    <= 1'b0;
      post_second <= 1'b0;
      idx         <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        NV_IDLE: begin
          if (start) begin
            st          <= NV_PRE;
            idx         <= '0;
            len_q       <= len;
            post_second <= 1'b0;
            is_reset    <= (op == OP_RESET);
            case (op)
              OP_RESET: begin pre_pat <= 6'b011111; pre_left <= 3'd6; end
              OP_IR:    begin pre_pat <= 6'b000011; pre_left <= 3'd4; end
              default:  begin pre_pat <= 6'b000001; pre_left <= 3'd3; end
            endcase
          end
        end
        NV_PRE: begin
          if (fall) begin
            pre_pat  <= pre_pat >> 1;
            pre_left <= pre_left - 3'd1;
            if (pre_left == 3'd1) begin
              if (is_reset) begin
                st   <= NV_IDLE;
                done <= 1'b1;
              end else begin
                st <= NV_SHIFT;
              end
            end
          end
        end
        NV_SHIFT: begin
          if (fall) begin
            if (last_bit) st <= NV_POST;
            else          idx <= idx + ONE;
          end
        end
        default: begin
          if (fall) begin
            if (post_second) begin
              st   <= NV_IDLE;
              done <= 1'b1;
            end else begin
              post_second <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tap_shift_dp.sv
module tap_shift_dp #(
  parameter int unsigned MAX_BITS = 64,
  parameter int unsigned LEN_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] data_in,
  input  logic                shift_rise,
  input  logic                shift_fall,
  input  logic [LEN_W-1:0]    idx,
  input  logic                tdo,
  output logic                tdi,
  output logic [MAX_BITS-1:0] captured
);
  logic [MAX_BITS-1:0] sh;
  logic                cap_stb;

  assign tdi = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cap_stb <= 1'b0;
    end else begin
      cap_stb <= shift_rise;
      if (load)            sh <= data_in;
      else if (shift_fall) sh <= sh >> 1;
    end
  end

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       captured[g] <= 1'b0;
      else if (load)                                    captured[g] <= 1'b0;
      else if (cap_stb && (idx == LEN_W'(g)))           captured[g] <= tdo;
    end
  end
endmodule

// File: rtl/tap_host_seq.sv
module tap_host_seq
  import tap_host_pkg::*;
#(
  parameter int unsigned MAX_BITS = 64,
  parameter int unsigned DIV_W    = 16,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [MAX_BITS-1:0] cmd_data,
  input  logic [DIV_W-1:0]    clk_div,
  output logic                rsp_valid,
  output logic [MAX_BITS-1:0] rsp_data,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  input  logic                tdo
);
  logic             busy, accept;
  logic [LEN_W-1:0] len_c, idx;
  logic [DIV_W-1:0] div_q;
  logic             level, rise, fall;
  logic             tms_c, in_shift, shift_rise, shift_fall, dp_tdi;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;

  always_comb begin
    if (cmd_len == '0)                      len_c = LEN_W'(1);
    else if (cmd_len > LEN_W'(MAX_BITS))    len_c = LEN_W'(MAX_BITS);
    else                                    len_c = cmd_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (accept) div_q <= clk_div;
  end

  tap_tck_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(div_q),
    .level(level), .rise(rise), .fall(fall)
  );

  tap_nav_fsm #(.LEN_W(LEN_W)) u_nav (
    .clk(clk), .rst_n(rst_n), .start(accept), .op(tap_op_e'(cmd_op)),
    .len(len_c), .rise(rise), .fall(fall), .busy(busy), .tms(tms_c),
    .in_shift(in_shift), .shift_rise(shift_rise), .shift_fall(shift_fall),
    .idx(idx), .done(rsp_valid)
  );

  tap_shift_dp #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(accept), .data_in(cmd_data),
    .shift_rise(shift_rise), .shift_fall(shift_fall), .idx(idx),
    .tdo(tdo), .tdi(dp_tdi), .captured(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck <= 1'b0;
      tms <= 1'b0;
      tdi <= 1'b0;
    end else begin
      tck <= level;
      tms <= tms_c;
      tdi <= in_shift && dp_tdi;
    end
  end
endmodule

// File: rtl/tap_host_seq_chk.sv
module tap_host_seq_chk #(
  parameter int unsigned MAX_BITS = 64,
  parameter int unsigned DIV_W    = 16,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                rsp_valid,
  input logic [MAX_BITS-1:0] rsp_data,
  input logic                tck,
  input logic                tms,
  input logic                tdi
);
  AST_EDGE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> ($stable(tms) && $stable(tdi))); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cmd_ready && !$past(cmd_ready))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_ready) && cmd_ready) |-> (!tck && !tms && !tdi)); // R11
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_ready) && cmd_ready && !rsp_valid) |-> $stable(rsp_data)); // R7
endmodule

bind tap_host_seq tap_host_seq_chk #(.MAX_BITS(MAX_BITS), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/tap_host_seq_bench.sv
module tap_host_seq_bench;
  localparam int MB = 64;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [6:0]    cmd_len = '0;
  logic [MB-1:0] cmd_data = '0;
  logic [DW-1:0] clk_div = '0;
  logic          rsp_valid;
  logic [MB-1:0] rsp_data;
  logic          tck, tms, tdi;
  logic          tdo = 1'b0;

  always #10 clk = ~clk;

  tap_host_seq #(.MAX_BITS(MB), .DIV_W(DW)) u_tap_host_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_data(cmd_data), .clk_div(clk_div),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Behavioural target port: 4-bit instruction, 8-bit data register (instr 1), else 1-bit bypass
  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHD, E1D, PDR, E2D, UDR,
                            SIR, CIR, SHI, E1I, PIR, E2I, UIR} tst_e;
  tst_e       st = SHI;
  logic [3:0] ir = 4'h7, ish = 4'h0;
  logic [7:0] dreg = 8'h3C, dsh = 8'h00;
  logic       bsh = 1'b0;
  bit         saw_tlr = 0;
  logic [127:0] tms_log;
  int         nlog = 0;

  always @(posedge tck) begin
    tms_log[nlog] = tms;
    nlog = nlog + 1;
    if (st == TLR) begin ir <= 4'h1; saw_tlr = 1; end
    case (st)
      CDR: if (ir == 4'h1) dsh <= dreg; else bsh <= 1'b0;
      SHD: if (ir == 4'h1) dsh <= {tdi, dsh[7:1]}; else bsh <= tdi;
      UDR: if (ir == 4'h1) dreg <= dsh;
      CIR: ish <= 4'b0101;
      SHI: ish <= {tdi, ish[3:1]};
      UIR: ir <= ish;
      default: ;
    endcase
    case (st)
      TLR: st <= tms ? TLR : RTI;
      RTI: st <= tms ? SDR : RTI;
      SDR: st <= tms ? SIR : CDR;
      CDR: st <= tms ? E1D : SHD;
      SHD: st <= tms ? E1D : SHD;
      E1D: st <= tms ? UDR : PDR;
      PDR: st <= tms ? E2D : PDR;
      E2D: st <= tms ? UDR : SHD;
      UDR: st <= tms ? SDR : RTI;
      SIR: st <= tms ? TLR : CIR;
      CIR: st <= tms ? E1I : SHI;
      SHI: st <= tms ? E1I : SHI;
      E1I: st <= tms ? UIR : PIR;
      PIR: st <= tms ? E2I : PIR;
      E2I: st <= tms ? UIR : SHI;
      default: st <= tms ? SDR : RTI;
    endcase
  end

  always @(negedge tck) begin
    if (st == SHD)      tdo <= (ir == 4'h1) ? dsh[0] : bsh;
    else if (st == SHI) tdo <= ish[0];
    else                tdo <= 1'b0;
  end

  // Port monitors, sampled away from the active clock edge
  logic p_tck = 0, p_tms = 0, p_tdi = 0;
  int   edge_bad = 0, pulses = 0, hi_run = 0, last_hi = 0, lo_run = 0, last_lo = 0;
  always @(negedge clk) begin
    if (tck && !p_tck && (tms != p_tms || tdi != p_tdi)) edge_bad++;
    if (rsp_valid) pulses++;
    if (tck) hi_run++; else if (p_tck) begin last_hi = hi_run; hi_run = 0; end
    if (!tck && rst_n && !cmd_ready) lo_run++; else if (!p_tck && tck) begin last_lo = lo_run; lo_run = 0; end
    p_tck = tck; p_tms = tms; p_tdi = tdi;
  end

  function automatic logic exp_tms(input logic [1:0] op, input int n, input int k);
    int pre;
    if (op == 2'd0) return (k < 5);
    pre = (op == 2'd1) ? 4 : 3;
    if (k < pre) return (op == 2'd1) ? (k < 2) : (k == 0);
    if (k < pre + n) return (k == pre + n - 1);
    return (k == pre + n);
  endfunction

  function automatic int exp_cnt(input logic [1:0] op, input int n);
    if (op == 2'd0) return 6;
    return ((op == 2'd1) ? 4 : 3) + n + 2;
  endfunction

  logic [63:0] res;
  bit          busy_seen;

  task automatic run_cmd(input logic [1:0] op, input logic [6:0] len, input logic [63:0] data,
                         input logic [3:0] div);
    @(negedge clk);
    nlog = 0; pulses = 0; saw_tlr = 0;
    cmd_op = op; cmd_len = len; cmd_data = data; clk_div = div; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data = ~data;
    clk_div = ~div;
    busy_seen = !cmd_ready;
    while (!rsp_valid) @(negedge clk);
    res = rsp_data;
    @(negedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  len;
    logic [63:0] data;
    logic [3:0]  div;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd0, 7'd0,  64'h0,                 4'd1, 64'h0},
    '{2'd2, 7'd8,  64'hA5,                4'd0, 64'h3C},
    '{2'd2, 7'd8,  64'h5A,                4'd2, 64'hA5},
    '{2'd1, 7'd4,  64'hF,                 4'd1, 64'h5},
    '{2'd3, 7'd3,  64'h5,                 4'd0, 64'h2},
    '{2'd1, 7'd4,  64'h1,                 4'd3, 64'h5},
    '{2'd2, 7'd16, 64'h1234,              4'd0, 64'h345A},
    '{2'd2, 7'd64, 64'hDEADBEEF01234567,  4'd1, 64'hADBEEF0123456712},
    '{2'd2, 7'd1,  64'h1,                 4'd0, 64'h0},
    '{2'd2, 7'd8,  64'h0,                 4'd0, 64'hEF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cmd_ready && !tck && !tms && !tdi && !rsp_valid, "R1 in reset",
        {59'd0, cmd_ready, tck, tms, tdi, rsp_valid}, 64'h10);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !tck && !tms && !tdi && !rsp_valid, "R1 after reset",
        {59'd0, cmd_ready, tck, tms, tdi, rsp_valid}, 64'h10);

    for (int v = 0; v < 10; v++) begin
      automatic vec_t t = VEC[v];
      automatic bit   pat_ok;
      run_cmd(t.op, t.len, t.data, t.div);
      chk(res == t.exp, $sformatf("R6 R7 R8 captured bits, vector %0d", v), res, t.exp);
      pat_ok = (nlog == exp_cnt(t.op, int'(t.len)));
      for (int k = 0; k < nlog; k++)
        if (tms_log[k] != exp_tms(t.op, int'(t.len), k)) pat_ok = 0;
      chk(pat_ok, $sformatf("R3 R4 R5 mode-select pattern, vector %0d", v),
          64'(nlog), 64'(exp_cnt(t.op, int'(t.len))));
      chk(st == RTI, $sformatf("R4 R5 target parked, vector %0d", v), 64'(st), 64'(RTI));
      chk(busy_seen && pulses == 1, $sformatf("R2 handshake, vector %0d", v),
          64'(pulses), 64'd1);
      chk(!tck && !tms && !tdi && cmd_ready, $sformatf("R11 idle lines, vector %0d", v),
          {60'd0, tck, tms, tdi, cmd_ready}, 64'h1);
      if (t.op == 2'd0)
        chk(saw_tlr && ir == 4'h1, "R3 reset reached Test-Logic-Reset", {59'd0, saw_tlr, ir}, 64'h11);
    end

    // R6: readback of the final 8'h00 write
    run_cmd(2'd2, 7'd8, 64'h96, 4'd3);
    chk(res == 64'h0, "R6 readback of zero payload", res, 64'h0);
    // R10: half-period of divider 3 is 4 clocks in both phases
    chk(last_hi == 4, "R10 tck high phase", 64'(last_hi), 64'd4);
    chk(last_lo == 4, "R10 tck low phase", 64'(last_lo), 64'd4);
    // R8: length 0 acts as 1 bit, length above max acts as max
    run_cmd(2'd2, 7'd0, 64'h1, 4'd0);
    chk(res == 64'h0 && dreg == 8'hCB, "R8 zero length", {res[55:0], dreg}, 64'hCB);
    run_cmd(2'd2, 7'd100, 64'h0, 4'd0);
    chk(nlog == 69 && res == 64'hCB, "R8 clamped length", 64'(nlog), 64'd69);
    chk(edge_bad == 0, "R9 no change at tck rise", 64'(edge_bad), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule